// File: doc/BRIEF.md
# Set-Associative Tag Directory

The block tracks which memory blocks are resident in a set-associative cache without holding any of their data. Every way keeps a tag and a valid flag. A request presents an address. One clock edge later the block reports whether the address hit, and which way served it or was allocated for it. On a miss the chosen way takes the new tag at once, so the next access to the same block hits.

A 2-bit mode input selects the victim policy that is used when a set is full. The three policies are least-recently-used by per-set generation stamps, first-in-first-out by fill order, and pseudo-random from a shift-register sequence. A miss always fills the lowest-numbered empty way before any policy is consulted. The mode is a static setting: it is changed only together with a reset. Block size, way count and set count are elaboration parameters, and each must be a power of two. The set count equals the cache capacity divided by (block bytes × ways).

Top module: `tag_directory`

## Requirements
- R1: With the default parameters, address bits [3:0] are the byte offset, bits [6:4] select one of 8 sets, and bits [31:7] form the 25-bit tag; in general the offset is log2(BLOCK_BYTES) bits, the set index is the next log2(SETS) bits, and the tag is the rest.
- R2: A request with req_valid high at a clock edge gives resp_valid high after that edge, together with hit and way. hit is 1 exactly when a valid way of the indexed set holds the request tag, and way then names that way.
- R3: On a miss, when the set has an empty way, the lowest-numbered empty way is filled with the request tag and reported in way.
- R4: In mode 0 (LRU), every hit or fill writes the set's generation counter into the touched way's stamp, and the counter then increments. A miss in a full set evicts the way with the smallest stamp; on equal stamps the lowest index wins.
- R5: In mode 1 (FIFO), a miss in a full set evicts the way that was filled longest ago. Hits never change this order.
- R6: In mode 2 or 3 (random), a miss in a full set evicts the way given by the low log2(WAYS) bits of a 16-bit shift register. The register resets to 0xACE1. On every accepted request in any mode it shifts left by one, and the new bit 0 is the XOR of bits 15, 13, 12 and 10.
- R7: A synchronous reset empties every way, clears all stamps, generation counters and FIFO pointers, and drives resp_valid low. The first access after reset misses.
- R8: An access changes only the set it indexes. Fills and evictions in one set never remove a tag from another set.
- R9: A cycle with req_valid low produces resp_valid low on the next edge and leaves the contents unchanged.
- R10: Addresses that differ only in the byte offset map to the same block and hit the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Victim policy: 0 LRU, 1 FIFO, 2/3 random |
| req_valid | input | 1 | Lookup request this cycle |
| addr | input | ADDR_W | Byte address of the request |
| resp_valid | output | 1 | Result of the previous cycle's request is present |
| hit | output | 1 | Request tag was resident |
| way | output | log2(WAYS) | Way that hit, or way that was filled |

## Verification
Each policy first runs a directed sequence. Four tags fill one set, so the empty-way order can be seen. A hit on the oldest way follows, and then a fifth tag. That fifth miss separates the policies: LRU passes over the way that was just touched, FIFO evicts it anyway, and random follows the shift-register value. Offset-only variations and a burst of conflicting tags in a neighbouring set check that block mapping and set isolation hold. A long stream of random addresses then follows, drawn from a few tags over a few sets, with idle cycles mixed in. It keeps sets full and evicting, so every hit, way and fill is compared with a reference model built from the requirements.

// File: rtl/tag_directory.sv
module tag_directory #(
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 16,
  parameter int WAYS        = 4,
  parameter int SETS        = 8,
  parameter int STAMP_W     = 16,
  parameter logic [15:0] RNG_SEED = 16'hACE1,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] addr,
  output logic              resp_valid,
  output logic              hit,
  output logic [WAY_W-1:0]  way
);
  localparam int OFF_W = $clog2(BLOCK_BYTES);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam logic [1:0] M_LRU  = 2'd0;
  localparam logic [1:0] M_FIFO = 2'd1;

  logic [WAYS-1:0]    vld   [SETS];
  logic [TAG_W-1:0]   tags  [SETS][WAYS];
  logic [STAMP_W-1:0] stamp [SETS][WAYS];
  logic [STAMP_W-1:0] gen   [SETS];
  logic [WAY_W-1:0]   fptr  [SETS];
  logic [15:0]        rng;

  wire [IDX_W-1:0] idx = addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0] tg  = addr[ADDR_W-1 -: TAG_W];
  wire [15:0] rng_nx = {rng[14:0], rng[15] ^ rng[13] ^ rng[12] ^ rng[10]};

  logic [WAYS-1:0]    match;
  logic               any_hit, any_inv;
  logic [WAY_W-1:0]   hit_way, inv_way, lru_way, victim, pick;
  logic [STAMP_W-1:0] lru_min;

  always_comb begin
    any_hit = 1'b0;
    any_inv = 1'b0;
    hit_way = '0;
    inv_way = '0;
    match   = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      match[w] = vld[idx][w] && (tags[idx][w] == tg);
      if (match[w]) begin
        any_hit = 1'b1;
        hit_way = WAY_W'(w);
      end
      if (!vld[idx][w]) begin
        any_inv = 1'b1;
        inv_way = WAY_W'(w);
      end
    end
    lru_way = '0;
    lru_min = stamp[idx][0];
    for (int w = 1; w < WAYS; w++) begin
      if (stamp[idx][w] < lru_min) begin
        lru_min = stamp[idx][w];
        lru_way = WAY_W'(w);
      end
    end
    case (mode)
      M_LRU:   victim = lru_way;
      M_FIFO:  victim = fptr[idx];
      default: victim = rng[WAY_W-1:0];
    endcase
    pick = any_hit ? hit_way : (any_inv ? inv_way : victim);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      hit        <= 1'b0;
      way        <= '0;
      rng        <= RNG_SEED;
      for (int s = 0; s < SETS; s++) begin
        vld[s]  <= '0;
        gen[s]  <= '0;
        fptr[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          stamp[s][w] <= '0;
          tags[s][w]  <= '0;
        end
      end
    end else begin
      resp_valid <= req_valid;
      if (req_valid) begin
        hit              <= any_hit;
        way              <= pick;
        rng              <= rng_nx;
        stamp[idx][pick] <= gen[idx];
        gen[idx]         <= gen[idx] + 1'b1;
        if (!any_hit) begin
          vld[idx][pick]  <= 1'b1;
          tags[idx][pick] <= tg;
          if (!any_inv && mode == M_FIFO)
            fptr[idx] <= fptr[idx] + 1'b1;
        end
      end
    end
  end

  a_r2_resp_follows_req: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> resp_valid);
  a_r9_no_req_no_resp: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !resp_valid);
  a_r2_single_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match));
  a_r3_fill_marks_valid: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !hit) |-> vld[$past(idx)][way]);
  a_r3_repeat_hits: assert property (@(posedge clk) disable iff (rst)
    (req_valid && $past(req_valid) && !$past(rst) && addr == $past(addr)) |=> hit);
  a_r6_rng_nonzero: assert property (@(posedge clk) disable iff (rst)
    rng != 16'h0);
endmodule

// File: tb/tag_directory_tb.sv
`timescale 1ns/1ps
module tag_directory_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode = 2'd0;
  logic        req_valid = 1'b0;
  logic [31:0] addr = '0;
  logic        resp_valid, hit;
  logic [1:0]  way;

  always #2 clk = ~clk;

  tag_directory dut_i (
    .clk(clk), .rst(rst), .mode(mode), .req_valid(req_valid), .addr(addr),
    .resp_valid(resp_valid), .hit(hit), .way(way)
  );

  int checks = 0;
  int errors = 0;

  bit          mv [8][4];
  logic [24:0] mt [8][4];
  logic [15:0] ms [8][4];
  logic [15:0] mg [8];
  logic [1:0]  mf [8];
  logic [15:0] ml;

  task automatic check(input string rq, input string nm, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got=%0d exp=%0d", rq, nm, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < 8; s++) begin
      mg[s] = '0; mf[s] = '0;
      for (int w = 0; w < 4; w++) begin mv[s][w] = 1'b0; mt[s][w] = '0; ms[s][w] = '0; end
    end
    ml = 16'hACE1;
  endtask

  task automatic model_access(input logic [31:0] a, output bit eh, output int ew);
    int s, v;
    bit full;
    logic [24:0] t;
    logic [15:0] mn;
    s = int'(a[6:4]);
    t = a[31:7];
    eh = 1'b0; ew = -1;
    for (int w = 0; w < 4; w++)
      if (ew < 0 && mv[s][w] && mt[s][w] == t) begin eh = 1'b1; ew = w; end
    if (!eh) begin
      full = 1'b1;
      for (int w = 0; w < 4; w++)
        if (full && !mv[s][w]) begin full = 1'b0; ew = w; end
      if (full) begin
        if (mode == 2'd0) begin
          v = 0; mn = ms[s][0];
          for (int w = 1; w < 4; w++) if (ms[s][w] < mn) begin mn = ms[s][w]; v = w; end
        end else if (mode == 2'd1) begin
          v = int'(mf[s]); mf[s] = mf[s] + 2'd1;
        end else begin
          v = int'(ml[1:0]);
        end
        ew = v;
      end
      mv[s][ew] = 1'b1;
      mt[s][ew] = t;
    end
    ms[s][ew] = mg[s];
    mg[s] = mg[s] + 16'd1;
    ml = {ml[14:0], ml[15] ^ ml[13] ^ ml[12] ^ ml[10]};
  endtask

  task automatic access(input logic [31:0] a, input string rq);
    bit eh;
    int ew;
    @(negedge clk);
    req_valid = 1'b1;
    addr = a;
    model_access(a, eh, ew);
    @(posedge clk); #1;
    check(rq, "resp_valid", int'(resp_valid), 1);
    check(rq, "hit", int'(hit), int'(eh));
    check(rq, "way", int'(way), ew);
    req_valid = 1'b0;
  endtask

  task automatic idle(input string rq);
    @(negedge clk);
    req_valid = 1'b0;
    addr = $urandom;
    @(posedge clk); #1;
    check(rq, "resp_valid idle", int'(resp_valid), 0);
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst = 1'b1; mode = m; req_valid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    #1;
    check("R7", "resp_valid after reset", int'(resp_valid), 0);
  endtask

  function automatic logic [31:0] mk(input int t, input int s, input int o);
    return (32'(t) << 7) | (32'(s) << 4) | 32'(o);
  endfunction

  task automatic run_mode(input logic [1:0] m, input string prq);
    do_reset(m);
    access(mk(9, 2, 3), "R7");
    for (int t = 0; t < 4; t++) access(mk(16 + t, 0, 0), "R3");
    access(mk(16, 0, 0), "R2");
    access(mk(16, 0, 15), "R10");
    access(mk(17, 0, 7), "R1");
    access(mk(20, 0, 0), prq);
    access(mk(21, 0, 0), prq);
    for (int t = 0; t < 6; t++) access(mk(40 + t, 1, t), "R8");
    access(mk(20, 0, 0), "R8");
    access(mk(21, 0, 0), "R8");
    idle("R9");
    access(mk(21, 0, 9), "R9");
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 7) == 0) idle("R9");
      else access(mk($urandom_range(0, 6), $urandom_range(0, 2), $urandom_range(0, 15)), prq);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    run_mode(2'd0, "R4");
    run_mode(2'd1, "R5");
    run_mode(2'd2, "R6");
    run_mode(2'd3, "R6");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R2 watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule